// File: doc/BRIEF.md
# Dual-Page Scaler Task Sequencer

This block decides which parameter set drives a video scaler. It holds three register pages. Page A and page B each describe a complete scaling task. The third page is kept for raw vertical-blanking capture. A sequencer picks one page at well-defined line boundaries and presents that page's source select, format, input window, output size and the three scaling controls as a stable, shadowed set. It also produces a per-pixel qualifier. The qualifier is true only while the current pixel lies inside the active page's input window.

An acquisition counter outside the block supplies the timing. It provides a line-start strobe with the line number, the field parity, and the pixel number with its valid flag. In alternating mode, whole fields go to A or B according to each page's parity enables. In region mode, one field is split at a programmed line: A runs above the split and B at and below it. The raw page pre-empts both over the first programmed lines of a field when its parity enable is set. When no enable matches, the sequencer is idle.

Top module: `scaler_task_seq`

## Requirements
- R1: After reset the active page output is 3 (idle), all page enables are clear and `win_vld` is 0.
- R2: A page whose enable bit for the current field parity is clear is never selected. When no candidate is enabled, `act_page` is 3 and `win_vld` stays 0.
- R3: In alternating mode (global address 0 bit 0 = 0), page A (code 0) is chosen at line 0 if it is enabled for the field parity. Otherwise page B (code 1) is chosen if it is enabled. Otherwise the block is idle. Page control word: bit 0 = source, bits 2:1 = format, bit 3 = even-field enable, bit 4 = odd-field enable (`fld_odd` = 1 means odd).
- R4: In region mode (global address 0 bit 0 = 1), lines below the split line (global address 1) use A and lines from the split line on use B, each gated by its parity enable. The switch happens at the line start of the split line.
- R5: The raw page (code 2) is selected for lines below the raw-line count (global address 2) when its parity enable is set. At the line start of the raw-line count the A/B rule is applied again.
- R6: `act_page` changes only on a line start whose line number is 0, the raw-line count, or (in region mode) the split line. Enable writes during a field do not alter it before such a boundary.
- R7: Page parameters are copied into shadow outputs at the boundary that selects the page. Writes to the live page, including the active one, do not change the outputs until the next boundary.
- R8: `win_vld` = busy AND `pix_vld` AND x0 <= `pix_idx` <= x1 AND y0 <= latched line <= y1, with inclusive bounds. The latched line is the `line_idx` of the most recent line start. Per-page addresses: 1 = x0, 2 = x1, 3 = y0, 4 = y1.
- R9: The shadow outputs equal the selected page's registers: 0 control, 5 output width, 6 output height, 7 prescale, 8 vertical scale, 9 phase step. Configuration writes use `cfg_page` 0–2 for the pages and 3 for the global registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_page | input | 2 | Target page: 0 A, 1 B, 2 raw, 3 global |
| cfg_addr | input | 4 | Register address within the page |
| cfg_wdata | input | DW | Write data |
| line_start | input | 1 | Strobe at the start of each line |
| line_idx | input | LW | Line number within the field, valid with line_start |
| fld_odd | input | 1 | Field parity, sampled at line 0 |
| pix_vld | input | 1 | Pixel qualifier from the acquisition counter |
| pix_idx | input | PW | Pixel number within the line |
| act_page | output | 2 | Active page: 0 A, 1 B, 2 raw, 3 idle |
| act_src | output | 1 | Active source select |
| act_fmt | output | 2 | Active format code |
| act_x0 | output | PW | Active input window first pixel |
| act_x1 | output | PW | Active input window last pixel |
| act_y0 | output | LW | Active input window first line |
| act_y1 | output | LW | Active input window last line |
| act_ow | output | PW | Active output width |
| act_oh | output | LW | Active output height |
| act_hpre | output | HPW | Active horizontal prescale factor |
| act_vsc | output | SW | Active vertical scale increment |
| act_hph | output | SW | Active horizontal phase step |
| win_vld | output | 1 | Pixel is inside the active input window |

## Verification
The hardest case to reach is a write that lands on the live registers of the page already in use, in the middle of a field. The outputs must ignore it until a boundary arrives. A second hard case is the raw page and the region split overlapping in the same field. The bench writes configuration in the idle cycles between lines of a running field, then probes the shadow outputs and the window count on the next lines. It then sets the raw-line count below the split line and runs odd and even fields, so that all three selections and the hand-offs between them occur in one sequence. A behavioural model follows every clock and compares all outputs.

// File: rtl/scaler_task_seq.sv
module scaler_task_seq #(
  parameter int DW  = 16,
  parameter int PW  = 11,
  parameter int LW  = 10,
  parameter int HPW = 5,
  parameter int SW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_page,
  input  logic [3:0]     cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  input  logic           line_start,
  input  logic [LW-1:0]  line_idx,
  input  logic           fld_odd,
  input  logic           pix_vld,
  input  logic [PW-1:0]  pix_idx,
  output logic [1:0]     act_page,
  output logic           act_src,
  output logic [1:0]     act_fmt,
  output logic [PW-1:0]  act_x0,
  output logic [PW-1:0]  act_x1,
  output logic [LW-1:0]  act_y0,
  output logic [LW-1:0]  act_y1,
  output logic [PW-1:0]  act_ow,
  output logic [LW-1:0]  act_oh,
  output logic [HPW-1:0] act_hpre,
  output logic [SW-1:0]  act_vsc,
  output logic [SW-1:0]  act_hph,
  output logic           win_vld
);
  localparam int NPG = 3;
  localparam int CTW = 5;
  localparam logic [1:0] PG_A = 2'd0, PG_B = 2'd1, PG_RAW = 2'd2, PG_IDLE = 2'd3;

  logic [CTW-1:0] ctl_r  [NPG];
  logic [PW-1:0]  x0_r   [NPG];
  logic [PW-1:0]  x1_r   [NPG];
  logic [LW-1:0]  y0_r   [NPG];
  logic [LW-1:0]  y1_r   [NPG];
  logic [PW-1:0]  ow_r   [NPG];
  logic [LW-1:0]  oh_r   [NPG];
  logic [HPW-1:0] hpre_r [NPG];
  logic [SW-1:0]  vsc_r  [NPG];
  logic [SW-1:0]  hph_r  [NPG];

  logic          split_mode;
  logic [LW-1:0] split_ln, raw_lines;
  logic          par_q;
  logic [LW-1:0] line_q;
  logic [CTW-1:0] s_ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPG; p++) begin
        ctl_r[p]  <= '0;
        x0_r[p]   <= '0;
        x1_r[p]   <= '0;
        y0_r[p]   <= '0;
        y1_r[p]   <= '0;
        ow_r[p]   <= '0;
        oh_r[p]   <= '0;
        hpre_r[p] <= '0;
        vsc_r[p]  <= '0;
        hph_r[p]  <= '0;
      end
      split_mode <= 1'b0;
      split_ln   <= '0;
      raw_lines  <= '0;
    end else if (cfg_we) begin
      for (int p = 0; p < NPG; p++) begin
        if (cfg_page == 2'(p)) begin
          case (cfg_addr)
            4'd0: ctl_r[p]  <= cfg_wdata[CTW-1:0];
            4'd1: x0_r[p]   <= cfg_wdata[PW-1:0];
            4'd2: x1_r[p]   <= cfg_wdata[PW-1:0];
            4'd3: y0_r[p]   <= cfg_wdata[LW-1:0];
            4'd4: y1_r[p]   <= cfg_wdata[LW-1:0];
            4'd5: ow_r[p]   <= cfg_wdata[PW-1:0];
            4'd6: oh_r[p]   <= cfg_wdata[LW-1:0];
            4'd7: hpre_r[p] <= cfg_wdata[HPW-1:0];
            4'd8: vsc_r[p]  <= cfg_wdata[SW-1:0];
            4'd9: hph_r[p]  <= cfg_wdata[SW-1:0];
            default: ;
          endcase
        end
      end
      if (cfg_page == 2'd3) begin
        case (cfg_addr)
          4'd0: split_mode <= cfg_wdata[0];
          4'd1: split_ln   <= cfg_wdata[LW-1:0];
          4'd2: raw_lines  <= cfg_wdata[LW-1:0];
          default: ;
        endcase
      end
    end
  end

  wire par_now = (line_idx == '0) ? fld_odd : par_q;

  logic [NPG-1:0] pg_en;
  always_comb
    for (int p = 0; p < NPG; p++)
      pg_en[p] = par_now ? ctl_r[p][4] : ctl_r[p][3];

  logic [1:0] nxt_pg;
  always_comb begin
    nxt_pg = PG_IDLE;
    if (pg_en[2] && line_idx < raw_lines)
      nxt_pg = PG_RAW;
    else if (split_mode) begin
      if (line_idx < split_ln) nxt_pg = pg_en[0] ? PG_A : PG_IDLE;
      else                     nxt_pg = pg_en[1] ? PG_B : PG_IDLE;
    end else if (pg_en[0])
      nxt_pg = PG_A;
    else if (pg_en[1])
      nxt_pg = PG_B;
  end

  wire at_bnd = line_start &&
                (line_idx == '0 || line_idx == raw_lines ||
                 (split_mode && line_idx == split_ln));
  wire [1:0] cp = (nxt_pg == PG_IDLE) ? PG_A : nxt_pg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_page <= PG_IDLE;
      par_q    <= 1'b0;
      line_q   <= '0;
      s_ctl    <= '0;
      act_x0   <= '0;
      act_x1   <= '0;
      act_y0   <= '0;
      act_y1   <= '0;
      act_ow   <= '0;
      act_oh   <= '0;
      act_hpre <= '0;
      act_vsc  <= '0;
      act_hph  <= '0;
    end else begin
      if (line_start) line_q <= line_idx;
      if (line_start && line_idx == '0) par_q <= fld_odd;
      if (at_bnd) begin
        act_page <= nxt_pg;
        if (nxt_pg != PG_IDLE) begin
          s_ctl    <= ctl_r[cp];
          act_x0   <= x0_r[cp];
          act_x1   <= x1_r[cp];
          act_y0   <= y0_r[cp];
          act_y1   <= y1_r[cp];
          act_ow   <= ow_r[cp];
          act_oh   <= oh_r[cp];
          act_hpre <= hpre_r[cp];
          act_vsc  <= vsc_r[cp];
          act_hph  <= hph_r[cp];
        end
      end
    end
  end

  assign act_src = s_ctl[0];
  assign act_fmt = s_ctl[2:1];

  wire in_x = (pix_idx >= act_x0) && (pix_idx <= act_x1);
  wire in_y = (line_q  >= act_y0) && (line_q  <= act_y1);
  assign win_vld = (act_page != PG_IDLE) && pix_vld && in_x && in_y && (s_ctl[4:3] != 2'b00);
endmodule

// File: rtl/scaler_task_seq_chk.sv
module scaler_task_seq_chk #(
  parameter int PW = 11,
  parameter int LW = 10,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_start,
  input logic          pix_vld,
  input logic [PW-1:0] pix_idx,
  input logic [1:0]    act_page,
  input logic [PW-1:0] act_x0,
  input logic [PW-1:0] act_x1,
  input logic [LW-1:0] act_y1,
  input logic [SW-1:0] act_vsc,
  input logic          win_vld
);
  a_r6_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(act_page));

  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> ($stable(act_x0) && $stable(act_x1) && $stable(act_y1) && $stable(act_vsc)));

  a_r2_idle_no_win: assert property (@(posedge clk) disable iff (!rst_n)
    (act_page == 2'd3) |-> !win_vld);

  a_r8_win_needs_pix: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> pix_vld);

  a_r8_win_in_x: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> (pix_idx >= act_x0 && pix_idx <= act_x1));
endmodule

bind scaler_task_seq scaler_task_seq_chk #(.PW(PW), .LW(LW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_vld(pix_vld),
  .pix_idx(pix_idx), .act_page(act_page), .act_x0(act_x0), .act_x1(act_x1),
  .act_y1(act_y1), .act_vsc(act_vsc), .win_vld(win_vld)
);

// File: tb/scaler_task_seq_tb.sv
module scaler_task_seq_tb;
  localparam int CLK_NS = 10;
  localparam int DW = 16, PW = 11, LW = 10, HPW = 5, SW = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_page = 0;
  logic [3:0] cfg_addr = 0;
  logic [DW-1:0] cfg_wdata = 0;
  logic line_start = 0;
  logic [LW-1:0] line_idx = 0;
  logic fld_odd = 0, pix_vld = 0;
  logic [PW-1:0] pix_idx = 0;
  logic [1:0] act_page;
  logic act_src;
  logic [1:0] act_fmt;
  logic [PW-1:0] act_x0, act_x1, act_ow;
  logic [LW-1:0] act_y0, act_y1, act_oh;
  logic [HPW-1:0] act_hpre;
  logic [SW-1:0] act_vsc, act_hph;
  logic win_vld;

  int checks = 0, errs = 0, win_seen = 0;
  string tag = "R1";

  always #(CLK_NS/2) clk = ~clk;

  scaler_task_seq #(.DW(DW), .PW(PW), .LW(LW), .HPW(HPW), .SW(SW)) u_dut (.*);

  // reference model
  int m_reg [3][10];
  int m_mode, m_split, m_raw, m_par, m_line, m_pg;
  int m_sh [10];

  function automatic bit en_for(int p, int par);
    return par ? m_reg[p][0][4] : m_reg[p][0][3];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_reg[p, a]) m_reg[p][a] = 0;
      foreach (m_sh[a]) m_sh[a] = 0;
      m_mode = 0; m_split = 0; m_raw = 0; m_par = 0; m_line = 0; m_pg = 3;
    end else begin
      if (line_start) begin
        int L, par, pick;
        bit bnd;
        L = line_idx;
        par = (L == 0) ? fld_odd : m_par;
        bnd = (L == 0) || (L == m_raw) || (m_mode == 1 && L == m_split);
        if (bnd) begin
          if (en_for(2, par) && L < m_raw) pick = 2;
          else if (m_mode == 1) pick = (L < m_split) ? (en_for(0, par) ? 0 : 3) : (en_for(1, par) ? 1 : 3);
          else pick = en_for(0, par) ? 0 : (en_for(1, par) ? 1 : 3);
          m_pg = pick;
          if (pick != 3) foreach (m_sh[a]) m_sh[a] = m_reg[pick][a];
        end
        if (L == 0) m_par = fld_odd;
        m_line = L;
      end
      if (cfg_we) begin
        if (cfg_page == 3) begin
          if (cfg_addr == 0) m_mode = cfg_wdata[0];
          if (cfg_addr == 1) m_split = cfg_wdata[LW-1:0];
          if (cfg_addr == 2) m_raw = cfg_wdata[LW-1:0];
        end else if (cfg_addr <= 9) begin
          int v;
          case (cfg_addr)
            0: v = cfg_wdata[4:0];
            1, 2, 5: v = cfg_wdata[PW-1:0];
            3, 4, 6: v = cfg_wdata[LW-1:0];
            7: v = cfg_wdata[HPW-1:0];
            default: v = cfg_wdata[SW-1:0];
          endcase
          m_reg[cfg_page][cfg_addr] = v;
        end
      end
    end
  end

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit ew;
    ew = (m_pg != 3) && pix_vld && (m_sh[0][4:3] != 0) &&
         pix_idx >= m_sh[1] && pix_idx <= m_sh[2] && m_line >= m_sh[3] && m_line <= m_sh[4];
    if (win_vld) win_seen++;
    chk({tag, " R8 win_vld"}, win_vld, ew);
    chk({tag, " R6 act_page"}, act_page, m_pg);
    if (m_pg != 3) begin
      chk({tag, " R9 ctrl"}, {act_fmt, act_src}, m_sh[0][2:0]);
      chk({tag, " R9 x0"}, act_x0, m_sh[1]);
      chk({tag, " R9 x1"}, act_x1, m_sh[2]);
      chk({tag, " R9 y0"}, act_y0, m_sh[3]);
      chk({tag, " R9 y1"}, act_y1, m_sh[4]);
      chk({tag, " R9 ow"}, act_ow, m_sh[5]);
      chk({tag, " R9 oh"}, act_oh, m_sh[6]);
      chk({tag, " R9 hpre"}, act_hpre, m_sh[7]);
      chk({tag, " R9 vsc"}, act_vsc, m_sh[8]);
      chk({tag, " R9 hph"}, act_hph, m_sh[9]);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(int pg, int a, int d);
    cfg_we = 1; cfg_page = 2'(pg); cfg_addr = 4'(a); cfg_wdata = DW'(d);
    tick();
    cfg_we = 0;
  endtask

  task automatic line(int L, int np);
    line_start = 1; line_idx = LW'(L);
    tick();
    line_start = 0;
    for (int x = 0; x < np; x++) begin
      pix_vld = 1; pix_idx = PW'(x);
      tick();
    end
    pix_vld = 0;
    tick();
  endtask

  task automatic field(int odd, int first, int last, int np);
    fld_odd = odd[0];
    for (int L = first; L <= last; L++) line(L, np);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 idle page", act_page, 3);
    chk("R1 win_vld", win_vld, 0);
    rst_n = 1;
    tick();

    // R2: windows programmed but no enables
    tag = "R2";
    wr(0, 1, 0); wr(0, 2, 9); wr(0, 3, 0); wr(0, 4, 11);
    win_seen = 0;
    field(0, 0, 5, 6);
    chk("R2 idle page", act_page, 3);
    chk("R2 no window", win_seen, 0);

    // R3: alternating fields
    tag = "R3";
    wr(0, 0, 'h0D); wr(0, 1, 2); wr(0, 2, 6); wr(0, 3, 1); wr(0, 4, 8);
    wr(0, 5, 360); wr(0, 6, 144); wr(0, 7, 2); wr(0, 8, 'h0800); wr(0, 9, 'h1234);
    wr(1, 0, 'h12); wr(1, 1, 1); wr(1, 2, 3); wr(1, 3, 2); wr(1, 4, 5);
    wr(1, 5, 704); wr(1, 6, 288); wr(1, 7, 1); wr(1, 8, 'h0400); wr(1, 9, 'h0999);
    fld_odd = 0; line(0, 4);
    chk("R3 even field picks A", act_page, 0);
    chk("R9 A src", act_src, 1);
    chk("R9 A fmt", act_fmt, 2);
    field(0, 1, 5, 4);
    fld_odd = 1; line(0, 4);
    chk("R3 odd field picks B", act_page, 1);
    chk("R9 B fmt", act_fmt, 1);
    chk("R9 B vsc", act_vsc, 'h0400);
    field(1, 1, 5, 4);
    wr(0, 0, 'h19);
    fld_odd = 1; line(0, 4);
    chk("R3 A has priority", act_page, 0);

    // R8: window count, A x 2..6 y 1..8
    tag = "R8";
    win_seen = 0;
    field(0, 0, 11, 10);
    chk("R8 window pixel count", win_seen, 40);

    // R7 / R6: mid-field writes
    tag = "R7";
    fld_odd = 0; line(0, 10); line(1, 10);
    wr(0, 2, 4);
    line(2, 10);
    chk("R7 x1 still shadowed", act_x1, 6);
    tag = "R6";
    wr(0, 0, 'h00);
    line(3, 10);
    chk("R6 page held after disable", act_page, 0);
    field(0, 4, 9, 10);
    fld_odd = 0; line(0, 10);
    chk("R6 idle at next field", act_page, 3);
    wr(0, 0, 'h19);
    fld_odd = 0; line(0, 10);
    chk("R7 new x1 taken", act_x1, 4);

    // R4: region split at line 6
    tag = "R4";
    wr(1, 0, 'h1A);
    wr(3, 1, 6); wr(3, 0, 1);
    fld_odd = 0;
    for (int L = 0; L <= 5; L++) line(L, 8);
    chk("R4 above split uses A", act_page, 0);
    line(6, 8);
    chk("R4 split line uses B", act_page, 1);
    field(0, 7, 11, 8);
    chk("R4 B held to field end", act_page, 1);
    wr(1, 0, 'h10);
    field(0, 0, 6, 8);
    chk("R4 gated B gives idle", act_page, 3);
    field(0, 7, 11, 8);

    // R5: raw page on first 3 lines of odd fields
    tag = "R5";
    wr(1, 0, 'h1A);
    wr(2, 0, 'h16); wr(2, 1, 0); wr(2, 2, 9); wr(2, 3, 0); wr(2, 4, 2);
    wr(2, 8, 'h0100);
    wr(3, 2, 3);
    fld_odd = 1; line(0, 8);
    chk("R5 raw page line 0", act_page, 2);
    chk("R5 raw fmt", act_fmt, 3);
    line(1, 8); line(2, 8);
    chk("R5 raw page line 2", act_page, 2);
    line(3, 8);
    chk("R5 hand-off to A", act_page, 0);
    field(1, 4, 6, 8);
    chk("R5 then B at split", act_page, 1);
    field(1, 7, 11, 8);
    fld_odd = 0; line(0, 8);
    chk("R5 even field skips raw", act_page, 0);
    field(0, 1, 11, 8);

    // split in alternating mode ignored
    tag = "R6";
    wr(3, 0, 0);
    field(0, 0, 11, 8);
    chk("R6 no switch at split in alternating", act_page, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule